// File: doc/BRIEF.md
# Bit-Steered Modular Up/Down Counter Bank

This block holds the control values for the columns of a triangular swap network that has `N_LINES` lines. Column `i` (1 to `N_LINES`−1) owns one small counter. The counter's modulus is `i+1`, so its value `k` always lies between 0 and `i`. On each clock edge where the step enable is high, every counter moves by one at the same time. Bit `i−1` of a direction word sets the direction for column `i`: a 1 counts up and a 0 counts down. Counting up past `i` wraps to 0, and counting down past 0 wraps to `i`.

Next to each counter sits a one-hot decode that names the active cell of that column. The value `k = i` means the column passes its lines straight through. A value `k < i` means the column swaps line positions `k+1` and `i+1` (1-based). The network that consumes these selects is outside this block, and so is the source of the direction word. Synchronous reset puts every column into pass-through.

Top module: `tri_swap_ctrl_bank`

## Requirements
- R1: Reset (`rst` high at a rising edge) sets counter `i` to `i` for every column, whatever `step_en` and `dir_i` hold. Reset takes priority over stepping.
- R2: Counter `i`, read from `cnt_o[(i-1)*CW +: CW]` with `CW = $clog2(N_LINES)`, never exceeds `i`.
- R3: With `step_en` high and `dir_i[i-1]` = 1, counter `i` at a value below `i` rises by one at the next edge.
- R4: With `step_en` high and `dir_i[i-1]` = 0, counter `i` at a value above 0 falls by one at the next edge.
- R5: A count-up step from `i` gives 0, and a count-down step from 0 gives `i`.
- R6: With `step_en` low, no counter changes, whatever `dir_i` holds.
- R7: The select field for column `i` is `sel_o[(i-1)*N_LINES +: N_LINES]`. When counter `i` equals `i`, this field has only bit `i` set (pass-through).
- R8: When counter `i` holds `k < i`, its select field has only bit `k` set (swap of positions `k+1` and `i+1`). No select bit above position `i` is ever set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset to pass-through |
| step_en | input | 1 | When high, all counters step together |
| dir_i | input | N_LINES-1 | Direction per column; bit i-1 steers column i, 1 = up |
| cnt_o | output | (N_LINES-1)*CW | Packed counter values; column i at slice (i-1)*CW |
| sel_o | output | (N_LINES-1)*N_LINES | Packed one-hot selects; column i at slice (i-1)*N_LINES |

## Verification
Some properties can be checked on every cycle for every column, and the assertions do so. These cover the range bound, single steps in each direction, both wrap points, holding while disabled, reset to pass-through, and the one-hot shape of each select field with its pass-through bit. Other behaviour only shows up across a run. That includes all columns stepping in lockstep under mixed direction words, the different moduli interacting over long sequences, and reset arriving mid-run with stepping still enabled. The bench's scenarios show these, comparing every column against an arithmetic model through a sweep of all direction words and a long pseudo-random run.

// File: rtl/tsc_pkg.sv
`timescale 1ns/1ps
package tsc_pkg;
   // Width needed to hold values 0 .. n-1 (the largest modulus is n).
   function automatic int cnt_width(input int n);
      int w;
      w = $clog2(n);
      return (w < 1) ? 1 : w;
   endfunction
endpackage

// File: rtl/tsc_mod_counter.sv
`timescale 1ns/1ps
module tsc_mod_counter #(
   parameter int CW     = 3,
   parameter int MODMAX = 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          en,
   input  logic          up,
   output logic [CW-1:0] q
);
   localparam logic [CW-1:0] TOP  = CW'(MODMAX);
   localparam logic [CW-1:0] ZERO = '0;

   initial begin
      assert (MODMAX >= 1) else $error("tsc_mod_counter: MODMAX must be at least 1");
      assert (MODMAX < (1 << CW)) else $error("tsc_mod_counter: CW too narrow for MODMAX");
   end

   logic [CW-1:0] nxt;

   always_comb begin
      nxt = q;
      if (en) begin
         if (up) nxt = (q == TOP)  ? ZERO : q + CW'(1);
         else    nxt = (q == ZERO) ? TOP  : q - CW'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (rst) q <= TOP;
      else     q <= nxt;
   end

   // R1: reset lands on the pass-through value
   a_r1_reset_ident: assert property (@(posedge clk) rst |=> (q == TOP));
   // R2: value bounded by the modulus
   a_r2_in_range: assert property (@(posedge clk) disable iff (rst) q <= TOP);
   // R3: single step up
   a_r3_step_up: assert property (@(posedge clk) disable iff (rst)
      (en && up && q != TOP) |=> (q == $past(q) + CW'(1)));
   // R4: single step down
   a_r4_step_down: assert property (@(posedge clk) disable iff (rst)
      (en && !up && q != ZERO) |=> (q == $past(q) - CW'(1)));
   // R5: wrap in both directions
   a_r5_wrap_up: assert property (@(posedge clk) disable iff (rst)
      (en && up && q == TOP) |=> (q == ZERO));
   a_r5_wrap_down: assert property (@(posedge clk) disable iff (rst)
      (en && !up && q == ZERO) |=> (q == TOP));
   // R6: hold when stepping is off
   a_r6_hold: assert property (@(posedge clk) disable iff (rst) !en |=> $stable(q));
endmodule

// File: rtl/tsc_col_decode.sv
`timescale 1ns/1ps
module tsc_col_decode #(
   parameter int NL  = 8,
   parameter int CW  = 3,
   parameter int COL = 1
) (
   input  logic [CW-1:0] k,
   output logic [NL-1:0] sel
);
   initial begin
      assert (COL >= 1 && COL < NL) else $error("tsc_col_decode: COL out of range");
   end

   // Only positions 0..COL can be chosen; higher bits are tied low.
   for (genvar j = 0; j < NL; j++) begin : g_bit
      if (j <= COL) begin : g_live
         assign sel[j] = (k == CW'(j));
      end else begin : g_dead
         assign sel[j] = 1'b0;
      end
   end
endmodule

// File: rtl/tri_swap_ctrl_bank.sv
`timescale 1ns/1ps
module tri_swap_ctrl_bank #(
   parameter int N_LINES = 8,
   localparam int NCOL   = N_LINES - 1,
   localparam int CW     = tsc_pkg::cnt_width(N_LINES)
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   step_en,
   input  logic [NCOL-1:0]        dir_i,
   output logic [NCOL*CW-1:0]     cnt_o,
   output logic [NCOL*N_LINES-1:0] sel_o
);
   initial begin
      assert (N_LINES >= 2)  else $error("tri_swap_ctrl_bank: need at least 2 lines");
      assert (N_LINES <= 64) else $error("tri_swap_ctrl_bank: N_LINES above 64 not supported");
   end

   for (genvar c = 1; c <= NCOL; c++) begin : g_col
      logic [CW-1:0]      k;
      logic [N_LINES-1:0] s;

      tsc_mod_counter #(.CW(CW), .MODMAX(c)) u_cnt (
         .clk (clk),
         .rst (rst),
         .en  (step_en),
         .up  (dir_i[c-1]),
         .q   (k)
      );

      tsc_col_decode #(.NL(N_LINES), .CW(CW), .COL(c)) u_dec (
         .k   (k),
         .sel (s)
      );

      assign cnt_o[(c-1)*CW +: CW]           = k;
      assign sel_o[(c-1)*N_LINES +: N_LINES] = s;

      // R7: pass-through value selects bit c
      a_r7_ident_bit: assert property (@(posedge clk) disable iff (rst)
         (k == CW'(c)) |-> s[c]);
      // R8: exactly one cell active per column, and it is the counter's value
      a_r8_onehot: assert property (@(posedge clk) disable iff (rst)
         $countones(s) == 1);
      a_r8_tracks_cnt: assert property (@(posedge clk) disable iff (rst)
         $changed(k) |-> $changed(s));
   end
endmodule

// File: tb/tb_tri_swap_ctrl_bank.sv
`timescale 1ns/1ps
module tb_tri_swap_ctrl_bank;
   localparam int N  = 8;
   localparam int NC = N - 1;
   localparam int CW = tsc_pkg::cnt_width(N);

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic            step_en = 1'b0;
   logic [NC-1:0]   dir_i = '0;
   logic [NC*CW-1:0] cnt_o;
   logic [NC*N-1:0]  sel_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   int exp_v [N];
   string tag_v [N];

   always #10 clk = ~clk;

   tri_swap_ctrl_bank #(.N_LINES(N)) dut (
      .clk(clk), .rst(rst), .step_en(step_en),
      .dir_i(dir_i), .cnt_o(cnt_o), .sel_o(sel_o)
   );

   task automatic check_all();
      for (int i = 1; i <= NC; i++) begin
         int got;
         logic [N-1:0] gs, es;
         got = int'(cnt_o[(i-1)*CW +: CW]);
         n_cmp++;
         if (got != exp_v[i]) begin
            n_bad++;
            $display("FAIL %s col %0d count: actual=%0d expected=%0d", tag_v[i], i, got, exp_v[i]);
         end
         n_cmp++;
         if (got > i) begin   // R2 bound
            n_bad++;
            $display("FAIL R2 col %0d range: actual=%0d expected<=%0d", i, got, i);
         end
         gs = sel_o[(i-1)*N +: N];
         es = N'(1) << exp_v[i];
         n_cmp++;
         if (gs !== es) begin
            n_bad++;
            $display("FAIL %s col %0d select: actual=%b expected=%b",
                     (exp_v[i] == i) ? "R7" : "R8", i, gs, es);
         end
      end
   endtask

   task automatic tick(input logic r, input logic en, input logic [NC-1:0] d);
      rst = r; step_en = en; dir_i = d;
      @(posedge clk);
      for (int i = 1; i <= NC; i++) begin
         int p;
         p = exp_v[i];
         if (r) begin exp_v[i] = i; tag_v[i] = "R1"; end
         else if (!en) tag_v[i] = "R6";
         else if (d[i-1]) begin
            if (p == i) begin exp_v[i] = 0; tag_v[i] = "R5"; end
            else begin exp_v[i] = p + 1; tag_v[i] = "R3"; end
         end else begin
            if (p == 0) begin exp_v[i] = i; tag_v[i] = "R5"; end
            else begin exp_v[i] = p - 1; tag_v[i] = "R4"; end
         end
      end
      @(negedge clk);
      check_all();
   endtask

   initial begin
      logic [15:0] lf;
      lf = 16'hACE1;
      for (int i = 0; i < N; i++) begin exp_v[i] = i; tag_v[i] = "R1"; end
      @(negedge clk);
      // R1: reset state, with stepping requested during reset
      tick(1'b1, 1'b1, '1);
      tick(1'b1, 1'b0, '0);
      // R3/R5: all up, enough steps to wrap every column
      for (int s = 0; s < N + 1; s++) tick(1'b0, 1'b1, '1);
      // R6: hold with changing direction words
      tick(1'b0, 1'b0, '1);
      tick(1'b0, 1'b0, '0);
      tick(1'b0, 1'b0, NC'(16'h5555));
      // R4/R5: all down past zero
      for (int s = 0; s < N + 2; s++) tick(1'b0, 1'b1, '0);
      // sweep every direction word once, stepping each
      for (int d = 0; d < (1 << NC); d++) tick(1'b0, 1'b1, NC'(d));
      // R1: reset mid-run while enabled
      tick(1'b1, 1'b1, NC'(16'h2A));
      // long pseudo-random run with mixed enables
      for (int s = 0; s < 3000; s++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         tick((s % 997) == 500, lf[15] | lf[4], NC'(lf >> 3));
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog (all requirements): actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule